// File: doc/BRIEF.md
# Serial Octal DAC Command Front End

This block is the digital side of an eight-channel, 8-bit digital-to-analog converter. A host sends 16-bit command words over a three-wire link: a serial clock, an active-low frame select and a data line. Bits enter on falling edges of the serial clock, most significant bit first. A frame opens when the frame select falls and closes when it rises. The decoded command takes effect only when the frame closes. Each channel has a holding register and an output code register. The eight output codes are the values a converter core would use.

A persistent mode flag decides what a channel write does. In hold mode, a write lands only in the holding register. In direct mode, a write also reaches the output code. A broadcast command copies every holding register to its output at once. A serial data output carries the received stream to a downstream device, so that several devices can share the clock and frame select.

The serial clock, frame select and data inputs are asynchronous. A faster system clock samples each of them through a two-flop synchronizer.

Top module: `dac8_serial_front`

## Requirements
- R1: A synchronous active-high reset clears all holding and output codes to 0, selects hold mode and drives `dout` low.
- R2: While `sync_n` is low, each falling edge of `sclk` shifts `din` in, most significant bit first. No output code changes before `sync_n` rises.
- R3: A word with bit 15 = 0 is a channel write. Bits 14:12 give the channel (0 to 7), bits 11:4 give the code, and bits 3:0 are ignored.
- R4: In hold mode, a channel write updates only that channel's holding register. The output codes stay unchanged.
- R5: In direct mode, a channel write updates both the holding register and the output code of that channel when `sync_n` rises.
- R6: Top nibble 1000 selects hold mode and top nibble 1001 selects direct mode. The mode persists over any number of later frames until one of these two words changes it.
- R7: Top nibble 1010 copies all eight holding registers to the output codes in the same cycle, in either mode.
- R8: A frame is discarded and changes no register or mode if its number of `sclk` falling edges is zero or is not a multiple of 16.
- R9: Within a frame, `dout` stays low after falling edges 1 to 14 and goes high after edge 15. After edge k (k ≥ 16), it carries the bit received on edge k−15.
- R10: In a frame longer than 16 bits, only the last 16 received bits form the command. The first 16 bits emerge on `dout`, so a downstream device on the same `sclk` and `sync_n` decodes them.
- R11: If the last `sclk` falling edge and the `sync_n` rise reach the block in the same sampled cycle, that bit is counted before the frame is judged.
- R12: The top nibbles 1011 to 1111 leave all codes and the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than `sclk` |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sync_n | input | 1 | Active-low frame select; its rising edge executes the command |
| din | input | 1 | Serial data in; idles high |
| dout | output | 1 | Serial data out to the next device in a chain |
| codes | output | 64 | Eight 8-bit output codes; channel i in bits 8i+7:8i |

## Verification
The final serial clock fall and the frame-close rise can reach the block in the same sampled system cycle. In that cycle the block both shifts in the last bit and executes the command. The bench provokes this by driving `sclk` low and `sync_n` high at the same instant. It then judges that a direct-mode write built from the full 16 bits appears on its channel, which would fail if the last bit were dropped or the frame judged one bit short. A downstream instance wired to `dout` checks the chain path: the first word of a 32-bit frame must decode there and the second word in the upstream device.

// File: rtl/dac8_serial_front.sv
module dac8_serial_front #(
  parameter int NCH = 8,
  parameter int CW  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sclk,
  input  logic            sync_n,
  input  logic            din,
  output logic            dout,
  output logic [NCH*CW-1:0] codes
);
  localparam int WL = 16;
  localparam int AW = $clog2(NCH);

  logic [2:0] sclk_p, sync_p;
  logic [1:0] din_p;
  logic [WL-1:0] sr, sr_nx;
  logic [3:0] cnt, cnt_nx;
  logic full, full_nx, dout_q, mode_q;
  logic [CW-1:0] hold [NCH];
  logic [CW-1:0] outc [NCH];

  wire clk_fall = sclk_p[2] & ~sclk_p[1];
  wire start    = sync_p[2] & ~sync_p[1];
  wire stop     = ~sync_p[2] & sync_p[1];
  wire f        = clk_fall & ~sync_p[2];

  assign sr_nx   = f ? {sr[WL-2:0], din_p[1]} : sr;
  assign cnt_nx  = cnt + {3'b000, f};
  assign full_nx = full | (f & (cnt == 4'd15));
  wire exec      = stop & full_nx & (cnt_nx == 4'd0);
  wire [AW-1:0] ch = sr_nx[12 +: AW];
  wire [CW-1:0] cv = sr_nx[WL-5 -: CW];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p <= '0;
      sync_p <= '1;
      din_p  <= '1;
      sr     <= '0;
      cnt    <= '0;
      full   <= 1'b0;
      dout_q <= 1'b0;
      mode_q <= 1'b0;
      for (int i = 0; i < NCH; i++) begin
        hold[i] <= '0;
        outc[i] <= '0;
      end
    end else begin
      sclk_p <= {sclk_p[1:0], sclk};
      sync_p <= {sync_p[1:0], sync_n};
      din_p  <= {din_p[0], din};
      if (start) begin
        sr     <= {{(WL-1){1'b0}}, 1'b1};
        cnt    <= '0;
        full   <= 1'b0;
        dout_q <= 1'b0;
      end else begin
        sr   <= sr_nx;
        cnt  <= cnt_nx;
        full <= full_nx;
        if (f) dout_q <= sr[WL-2];
      end
      if (exec) begin
        if (!sr_nx[WL-1]) begin
          hold[ch] <= cv;
          if (mode_q) outc[ch] <= cv;
        end else begin
          case (sr_nx[14:12])
            3'b000: mode_q <= 1'b0;
            3'b001: mode_q <= 1'b1;
            3'b010: for (int i = 0; i < NCH; i++) outc[i] <= hold[i];
            default: ;
          endcase
        end
      end
    end
  end

  assign dout = dout_q;
  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign codes[g*CW +: CW] = outc[g];
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!dout_q && !mode_q && codes == '0)); // R1
  AST_NO_EARLY_UPDATE: assert property (@(posedge clk) disable iff (rst) !stop |=> $stable(codes)); // R2
  AST_HOLD_ONLY: assert property (@(posedge clk) disable iff (rst) (exec && !mode_q && !sr_nx[WL-1]) |=> $stable(codes)); // R4
  AST_MODE_STAY: assert property (@(posedge clk) disable iff (rst) !exec |=> $stable(mode_q)); // R6
  AST_SHORT_DISCARD: assert property (@(posedge clk) disable iff (rst) (stop && cnt_nx != 4'd0) |=> ($stable(codes) && $stable(mode_q))); // R8
  AST_MARK_LOW: assert property (@(posedge clk) disable iff (rst) (f && !full && cnt < 4'd14) |=> !dout_q); // R9
  AST_MARK_HIGH: assert property (@(posedge clk) disable iff (rst) (f && !full && cnt == 4'd14) |=> dout_q); // R9
endmodule

// File: tb/dac8_serial_front_test.sv
module dac8_serial_front_test;
  logic clk = 0, rst = 1, sclk = 0, sync_n = 1, din = 1;
  logic dout, dout2;
  logic [63:0] codes, codes2;
  int checks = 0, errors = 0;
  logic [7:0] eh [8];
  logic [7:0] eo [8];
  logic em;
  logic obs [0:63];
  int nobs;

  always #4 clk = ~clk;

  dac8_serial_front uut (.clk(clk), .rst(rst), .sclk(sclk), .sync_n(sync_n), .din(din), .dout(dout), .codes(codes));
  dac8_serial_front down (.clk(clk), .rst(rst), .sclk(sclk), .sync_n(sync_n), .din(dout), .dout(dout2), .codes(codes2));

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin eh[i] = 0; eo[i] = 0; end
    em = 0;
  endtask

  task automatic apply(input logic [15:0] x);
    if (!x[15]) begin
      eh[x[14:12]] = x[11:4];
      if (em) eo[x[14:12]] = x[11:4];
    end else case (x[14:12])
      3'd0: em = 0;
      3'd1: em = 1;
      3'd2: for (int i = 0; i < 8; i++) eo[i] = eh[i];
      default: ;
    endcase
  endtask

  task automatic check_codes(input string req);
    for (int i = 0; i < 8; i++)
      chk(codes[i*8 +: 8] === eo[i], req, codes[i*8 +: 8], eo[i]);
  endtask

  task automatic open_f();
    nobs = 0;
    sync_n = 0;
    w(4);
  endtask

  task automatic shift(input logic [63:0] v, input int n, input bit co);
    for (int i = n - 1; i >= 0; i--) begin
      din = v[i];
      w(3);
      sclk = 1;
      w(4);
      sclk = 0;
      if (co && i == 0) sync_n = 1;
      w(5);
      obs[nobs] = dout;
      nobs++;
    end
  endtask

  task automatic close_f();
    sync_n = 1;
    din = 1;
    w(6);
  endtask

  task automatic word(input logic [15:0] x);
    open_f();
    shift({48'd0, x}, 16, 0);
    close_f();
    apply(x);
  endtask

  task automatic do_reset();
    rst = 1; sync_n = 1; sclk = 0; din = 1;
    w(4);
    rst = 0;
    w(2);
    model_reset();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    check_codes("R1 reset codes");
    chk(dout === 0, "R1 reset dout", dout, 0);

    // R3 R4: hold-mode sweep, low nibble junk
    for (int c = 0; c < 8; c++) begin
      word({1'b0, 3'(c), 8'((c * 37 + 5) & 255), 4'(c + 9)});
      check_codes("R4 hold-only write");
    end
    word(16'hA000);
    check_codes("R7 update from hold mode");
    for (int c = 0; c < 8; c++) chk(eo[c] === 8'((c * 37 + 5) & 255), "R3 field decode", eo[c], 8'((c * 37 + 5) & 255));

    word(16'h9000);
    for (int c = 0; c < 8; c++) begin
      logic [15:0] x;
      x = {1'b0, 3'(c), 8'((c * 53 + 200) & 255), 4'hF};
      open_f();
      shift({48'd0, x}, 16, 0);
      w(6);
      check_codes("R2 no change before SYNC rise");
      close_f();
      apply(x);
      check_codes("R5 direct write");
    end
    word(16'h0000);
    check_codes("R6 direct mode persists");
    word(16'h3FE0);
    check_codes("R6 direct mode persists");

    word(16'h8000);
    word(16'h5110);
    check_codes("R6 back to hold mode");
    word(16'h2440);
    check_codes("R4 hold-only write");
    word(16'hA000);
    check_codes("R7 update");

    // R8 discards
    open_f(); shift(64'h0000_0000_0000_4CC0 >> 1, 15, 0); close_f();
    open_f(); shift(64'h0000_0000_0001_4DD0, 17, 0); close_f();
    open_f(); close_f();
    open_f(); shift(64'h0000_0000_0000_9000 >> 1, 15, 0); close_f();
    check_codes("R8 discarded frames");
    word(16'h6770);
    check_codes("R8 mode unchanged after discard");
    word(16'hA000);
    check_codes("R8 holds unchanged after discard");

    // R12 unused commands
    word(16'hB123);
    word(16'hF000);
    word(16'hC9A0);
    check_codes("R12 unused command");
    word(16'h1880);
    check_codes("R12 mode still hold");
    word(16'hA000);
    check_codes("R12 holds intact");

    // R11 coincident last edge and SYNC rise
    word(16'h9000);
    open_f();
    shift({48'd0, 16'h6A50}, 16, 1);
    close_f();
    apply(16'h6A50);
    check_codes("R11 coincident edge and SYNC rise");

    // R9 R10 chain
    do_reset();
    open_f(); shift({32'd0, 16'h9000, 16'h9000}, 32, 0); close_f();
    open_f(); shift({32'd0, 16'h2C30, 16'h5E70}, 32, 0); close_f();
    begin
      logic [31:0] v;
      v = {16'h2C30, 16'h5E70};
      for (int k = 1; k <= 32; k++) begin
        logic e;
        e = (k <= 14) ? 1'b0 : (k == 15) ? 1'b1 : v[31 - (k - 16)];
        chk(obs[k - 1] === e, "R9 dout sequence", obs[k - 1], e);
      end
    end
    chk(codes[5*8 +: 8] === 8'hE7, "R10 last word local", codes[5*8 +: 8], 8'hE7);
    chk(codes[2*8 +: 8] === 8'h00, "R10 first word not local", codes[2*8 +: 8], 8'h00);
    chk(codes2[2*8 +: 8] === 8'hC3, "R10 first word downstream", codes2[2*8 +: 8], 8'hC3);
    chk(codes2[5*8 +: 8] === 8'h00, "R10 downstream untouched", codes2[5*8 +: 8], 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule